// File: doc/BRIEF.md
# Configuration change protection unit

This block guards the path to system-critical registers and to the two protected instructions, program-memory store and program-memory load. Software unlocks either path by having the CPU write a signature byte to one protection register. A valid signature opens a short enable window for its mode. While a window is open, the matching unlock output is high, so a neighbouring register block or instruction decoder may accept a protected access. Interrupt servicing is also held off during the window.

There are two modes, and each has its own signature, its own window and its own set of closing events. A window stays open for at most four retired instructions. It closes early as soon as the CPU does something that could disturb the protected sequence. Writes that the DMA master makes to the protection register never open a window. The register reads back which windows are open. The protected registers themselves sit outside this block.

Class pulses mark instructions that the CPU executes. The bus write strobe covers writes from any master, and the master ID tells them apart.

Top module: `cfg_guard`

## Requirements
- R1: After a synchronous active-low reset, `ioreg_unlocked`, `spm_unlocked` and `irq_hold` are low, and `stat_rdata` is 0x00.
- R2: A CPU write (`bus_master` = 0) of 0xD8 to address `REG_ADDR` opens the register mode, and a CPU write of 0x9D opens the instruction mode. The matching unlock output is high from the cycle after the write. `stat_rdata` bit 0 reflects the register mode and bit 1 the instruction mode. Bits 7:2 read zero.
- R3: A mode stays open for four `instr_retire` pulses counted after the signature cycle. It is low in the cycle after the fourth pulse.
- R4: An open register mode closes in the cycle after any of `cls_mem_wr`, `cls_io_wr`, `cls_spm`, `cls_lpm` or `cls_sleep`. The unlock output is still high during the cycle of that event.
- R5: An open instruction mode closes in the cycle after `cls_mem_wr` or `cls_sleep`. `cls_io_wr`, `cls_spm` and `cls_lpm` leave it open.
- R6: `irq_hold` is high exactly when at least one mode is open.
- R7: A write from a non-CPU master (`bus_master` = 1) to `REG_ADDR` neither opens a window nor restarts an open one.
- R8: A CPU write of any other value to `REG_ADDR`, or of a signature to any other address, has no effect on either mode.
- R9: A valid signature written while its mode is open restarts that mode's count to four. The other mode is unaffected by it.
- R10: A signature write takes precedence over a closing event in the same cycle, so the mode is open afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| bus_wdata | input | 8 | Bus write data |
| bus_master | input | 1 | Bus master ID: 0 CPU, 1 DMA |
| instr_retire | input | 1 | One pulse per retired CPU instruction |
| cls_mem_wr | input | 1 | CPU data-memory write executed |
| cls_io_wr | input | 1 | CPU I/O write executed |
| cls_spm | input | 1 | Program-memory store executed |
| cls_lpm | input | 1 | Program-memory load executed |
| cls_sleep | input | 1 | Sleep instruction executed |
| ioreg_unlocked | output | 1 | Register mode open |
| spm_unlocked | output | 1 | Instruction mode open |
| irq_hold | output | 1 | Interrupt servicing held off |
| stat_rdata | output | 8 | Status read of the protection register |

## Verification
The assertions check the following on every cycle:
- the window count never exceeds four;
- every valid signature reloads the count;
- a closing event empties the count;
- a plain retire lowers the count by exactly one;
- at most one signature decodes at a time;
- a non-CPU write can never open the register mode.

Only the bench scenarios can show the visible timing. They cover the exact cycle in which the output drops, the output staying high during the protected write itself, and the different closing sets of the two modes. They also cover the restart rule and the precedence of a signature over a same-cycle closing event.

// File: rtl/cfg_guard_pkg.sv
// Shared constants for the configuration change protection unit.
// Assumes mode 0 is the register mode and mode 1 the instruction mode;
// the status bit position of each mode equals its index.
package cfg_guard_pkg;
    localparam int NUM_MODES = 2;
    localparam int NUM_EV    = 5;

    // Event vector bit positions
    localparam int EV_MEM_WR = 0;
    localparam int EV_IO_WR  = 1;
    localparam int EV_SPM    = 2;
    localparam int EV_LPM    = 3;
    localparam int EV_SLEEP  = 4;

    localparam logic [7:0] SIG_IOREG = 8'hD8;
    localparam logic [7:0] SIG_INSTR = 8'h9D;

    localparam logic MASTER_CPU = 1'b0;

    // Signature byte that opens the given mode
    function automatic logic [7:0] mode_sig(input int idx);
        return (idx == 0) ? SIG_IOREG : SIG_INSTR;
    endfunction

    // Events that close the given mode early
    function automatic logic [NUM_EV-1:0] mode_close_mask(input int idx);
        logic [NUM_EV-1:0] m;
        m = '0;
        m[EV_MEM_WR] = 1'b1;
        m[EV_SLEEP]  = 1'b1;
        if (idx == 0) begin
            m[EV_IO_WR] = 1'b1;
            m[EV_SPM]   = 1'b1;
            m[EV_LPM]   = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/cfg_guard_sigdec.sv
// Signature decoder: flags a CPU write of a mode's signature byte to the
// protection register. Assumes one bus write per cycle at most; writes
// from any master other than the CPU are never decoded.
module cfg_guard_sigdec
    import cfg_guard_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] REG_ADDR = 12'h034
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [7:0]           bus_wdata,
    input  logic                 bus_master,
    output logic [NUM_MODES-1:0] sig_hit
);
    logic reg_sel;

    // Qualify the write: CPU master, protection register address
    always_comb begin
        reg_sel = bus_we && (bus_master == MASTER_CPU)
                  && (bus_addr == REG_ADDR[ADDR_W-1:0]);
    end

    // Match the data byte against each mode's signature
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_match
        always_comb begin
            sig_hit[m] = reg_sel && (bus_wdata == mode_sig(m));
        end
    end

    AST_SIG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sig_hit));                                   // R2
endmodule

// File: rtl/cfg_guard_window.sv
// Enable window of one unlock mode: a count loaded on signature, lowered
// by each retired instruction and cleared by any event in CLOSE_MASK.
// Assumes a signature in the same cycle as a closing event wins.
module cfg_guard_window
    import cfg_guard_pkg::*;
#(
    parameter int              WIN_LEN    = 4,
    parameter logic [NUM_EV-1:0] CLOSE_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_hit,
    input  logic              retire,
    input  logic [NUM_EV-1:0] events,
    output logic              is_open
);
    localparam int CNT_W = $clog2(WIN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_LEN);

    logic [CNT_W-1:0] cnt;
    logic             close_now;

    // Early close when a masked event hits an open window
    always_comb begin
        close_now = |(events & CLOSE_MASK);
    end

    // Window count: load, clear, or count down on retire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (sig_hit) begin
            cnt <= CNT_LOAD;
        end else if (close_now) begin
            cnt <= '0;
        end else if (retire && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign is_open = (cnt != '0);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LOAD);                                     // R3
    AST_SIG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sig_hit |=> is_open && (cnt == CNT_LOAD));            // R9
    AST_EVENT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (!sig_hit && close_now) |=> !is_open);                // R4
    AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sig_hit && !close_now && retire && is_open)
        |=> (cnt == $past(cnt) - 1'b1));                      // R3
endmodule

// File: rtl/cfg_guard.sv
// Configuration change protection unit top. Decodes signature writes,
// runs one enable window per mode and exposes unlock, interrupt hold and
// status. Assumes class pulses describe CPU-executed instructions only.
module cfg_guard
    import cfg_guard_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] REG_ADDR = 12'h034,
    parameter int          WIN_LEN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_master,
    input  logic              instr_retire,
    input  logic              cls_mem_wr,
    input  logic              cls_io_wr,
    input  logic              cls_spm,
    input  logic              cls_lpm,
    input  logic              cls_sleep,
    output logic              ioreg_unlocked,
    output logic              spm_unlocked,
    output logic              irq_hold,
    output logic [7:0]        stat_rdata
);
    logic [NUM_MODES-1:0] sig_hit;
    logic [NUM_MODES-1:0] mode_open;
    logic [NUM_EV-1:0]    events;

    // Gather class pulses into the event vector
    always_comb begin
        events            = '0;
        events[EV_MEM_WR] = cls_mem_wr;
        events[EV_IO_WR]  = cls_io_wr;
        events[EV_SPM]    = cls_spm;
        events[EV_LPM]    = cls_lpm;
        events[EV_SLEEP]  = cls_sleep;
    end

    cfg_guard_sigdec #(
        .ADDR_W  (ADDR_W),
        .REG_ADDR(REG_ADDR)
    ) u_sigdec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_master(bus_master),
        .sig_hit   (sig_hit)
    );

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        cfg_guard_window #(
            .WIN_LEN   (WIN_LEN),
            .CLOSE_MASK(mode_close_mask(m))
        ) u_win (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_hit(sig_hit[m]),
            .retire (instr_retire),
            .events (events),
            .is_open(mode_open[m])
        );
    end

    // Output mapping: status bit index equals mode index
    always_comb begin
        ioreg_unlocked = mode_open[0];
        spm_unlocked   = mode_open[1];
        irq_hold       = |mode_open;
        stat_rdata     = '0;
        stat_rdata[NUM_MODES-1:0] = mode_open;
    end

    AST_DMA_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_master != MASTER_CPU) && !ioreg_unlocked)
        |=> !ioreg_unlocked);                                 // R7
    AST_HOLD_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (ioreg_unlocked || spm_unlocked) |-> irq_hold);       // R6
endmodule

// File: tb/cfg_guard_tb.sv
module cfg_guard_tb;
    localparam logic [11:0] RA = 12'h034;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we, bus_master, instr_retire;
    logic [11:0] bus_addr;
    logic [7:0]  bus_wdata, stat_rdata;
    logic        cls_mem_wr, cls_io_wr, cls_spm, cls_lpm, cls_sleep;
    logic        ioreg_unlocked, spm_unlocked, irq_hold;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cfg_guard u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_master(bus_master),
        .instr_retire(instr_retire), .cls_mem_wr(cls_mem_wr),
        .cls_io_wr(cls_io_wr), .cls_spm(cls_spm), .cls_lpm(cls_lpm),
        .cls_sleep(cls_sleep), .ioreg_unlocked(ioreg_unlocked),
        .spm_unlocked(spm_unlocked), .irq_hold(irq_hold),
        .stat_rdata(stat_rdata)
    );

    // {data[13:6], dma[5], n_retire[4:2], exp_io[1], exp_spm[0]}
    localparam logic [13:0] VEC [10] = '{
        {8'hD8, 1'b0, 3'd0, 1'b1, 1'b0},
        {8'hD8, 1'b0, 3'd3, 1'b1, 1'b0},
        {8'hD8, 1'b0, 3'd4, 1'b0, 1'b0},
        {8'h9D, 1'b0, 3'd0, 1'b0, 1'b1},
        {8'h9D, 1'b0, 3'd3, 1'b0, 1'b1},
        {8'h9D, 1'b0, 3'd4, 1'b0, 1'b0},
        {8'hD8, 1'b1, 3'd0, 1'b0, 1'b0},
        {8'h9D, 1'b1, 3'd0, 1'b0, 1'b0},
        {8'h55, 1'b0, 3'd0, 1'b0, 1'b0},
        {8'hD9, 1'b0, 3'd0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_we = 0; bus_addr = '0; bus_wdata = '0; bus_master = 0;
        instr_retire = 0; cls_mem_wr = 0; cls_io_wr = 0; cls_spm = 0;
        cls_lpm = 0; cls_sleep = 0;
    endtask

    // Apply current inputs for one cycle, return at next negedge
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic [7:0] d, input logic dma, input logic [11:0] a);
        bus_we = 1; bus_addr = a; bus_wdata = d; bus_master = dma;
        step();
    endtask

    task automatic retire(input int n);
        for (int i = 0; i < n; i++) begin
            instr_retire = 1;
            step();
        end
    endtask

    task automatic ev(input logic [4:0] e);
        {cls_sleep, cls_lpm, cls_spm, cls_io_wr, cls_mem_wr} = e;
        step();
    endtask

    task automatic chk_state(input string req, input logic io, input logic sp);
        chk(req, {7'b0, ioreg_unlocked}, {7'b0, io});
        chk(req, {7'b0, spm_unlocked}, {7'b0, sp});
        chk(req, stat_rdata, {6'b0, sp, io});
        chk(req, {7'b0, irq_hold}, {7'b0, io | sp});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        chk_state("R1 reset", 0, 0);

        // Vector walk: R2 R3 R7 R8
        foreach (VEC[i]) begin
            ev(5'b00001);
            wr(VEC[i][13:6], VEC[i][5], RA);
            retire(int'(VEC[i][4:2]));
            chk_state($sformatf("R2 R3 R7 R8 vec%0d", i), VEC[i][1], VEC[i][0]);
        end

        // R4: each class event closes register mode; high during event
        for (int e = 0; e < 5; e++) begin
            ev(5'b00001);
            wr(8'hD8, 0, RA);
            {cls_sleep, cls_lpm, cls_spm, cls_io_wr, cls_mem_wr} = 5'(1 << e);
            chk("R4 high during event", {7'b0, ioreg_unlocked}, 8'h01);
            step();
            chk("R4 closed after event", {7'b0, ioreg_unlocked}, 8'h00);
        end

        // R5: instruction mode closing set
        for (int e = 0; e < 5; e++) begin
            ev(5'b00001);
            wr(8'h9D, 0, RA);
            ev(5'(1 << e));
            chk($sformatf("R5 event%0d", e), {7'b0, spm_unlocked},
                (e == 0 || e == 4) ? 8'h00 : 8'h01);
        end

        // R6: both modes open together
        ev(5'b00001);
        wr(8'hD8, 0, RA);
        wr(8'h9D, 0, RA);
        chk_state("R6 both open", 1, 1);
        ev(5'b00010);
        chk_state("R6 only instr open", 0, 1);
        ev(5'b10000);
        chk_state("R6 none open", 0, 0);

        // R7: DMA signature does not restart an open window
        wr(8'hD8, 0, RA);
        retire(2);
        wr(8'hD8, 1, RA);
        retire(2);
        chk("R7 DMA no restart", {7'b0, ioreg_unlocked}, 8'h00);

        // R8: signature to another address
        wr(8'hD8, 0, RA + 12'd1);
        chk_state("R8 other address", 0, 0);

        // R9: restart of own mode, other mode unaffected
        wr(8'h9D, 0, RA);
        retire(1);
        wr(8'hD8, 0, RA);
        retire(3);
        wr(8'hD8, 0, RA);
        retire(3);
        chk_state("R9 restarted, instr expired", 1, 0);
        retire(1);
        chk("R9 closes after four", {7'b0, ioreg_unlocked}, 8'h00);

        // R10: signature wins over same-cycle closing event
        cls_mem_wr = 1; cls_sleep = 1;
        wr(8'hD8, 0, RA);
        chk("R10 sig wins", {7'b0, ioreg_unlocked}, 8'h01);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule